// File: doc/BRIEF.md
# Translation Access Permission Checker

This block sits behind a translation lookup and rules on one memory access per request. It takes the access kind, the privilege context, the alignment mask of the access size, a few control bits, a 32-bit word with one 2-bit access field per domain, and the attributes of the translation entry that hit. It then says whether the access may go ahead. If it may not, it also says why.

Each request is judged in a fixed order. The alignment test comes first, and only data accesses are tested. If translation is off, the address is used untranslated and only a cacheability verdict is produced. Otherwise the domain of the hit entry is looked up in the domain word. That lookup either raises a fault, grants the access outright, or passes it on to the permission decode. The permission decode also applies the execute-never bit to fetches.

The verdict is registered and comes out one cycle after the request strobe. It gives a fault class, marks the fault as instruction or data, carries the domain and write flag for data aborts, gives a subtype taken from the entry's section/page flag, and returns the faulting address.

Top module: `acc_perm_check`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and the other response outputs hold the verdict for that request. After reset `rsp_valid` is 0.
- R2: Reads and writes raise an alignment fault (class 1) when `(align_force || !allow_unaligned)` is true and `vaddr[MASK_W-1:0] & size_mask` is nonzero. This test takes priority over every other test. Fetches are never alignment-checked. The access kind encoding is 00 read, 01 write, 10 fetch, and 11 is treated as a read.
- R3: With `mmu_on` low, an access that passed R2 never faults. `rsp_cacheable` is 1 only when `remap_on` is high, both `attr_in0` and `attr_out0` are nonzero, and `type0` equals 2.
- R4: The domain value is bits `[2*ent_domain+1 : 2*ent_domain]` of `dacr`. A value of 0 raises a domain fault (class 2).
- R5: A domain value of 3 grants the access without any permission or execute-never check.
- R6: A domain value of 2, or an effective permission code of 4 under domain value 1, raises the unpredictable class (4).
- R7: Under domain value 1, the effective permission code decides the result, and an abort is reported as class 3. The codes are: 0 always aborts; 1 aborts when unprivileged; 2 aborts when unprivileged and writing; 3 never aborts; 5 aborts when unprivileged or writing; 6 and 7 abort on writes.
- R8: When `af_enable` is high, the effective permission code is `ent_perm` with bit 0 forced to 1.
- R9: Under domain value 1, a fetch also aborts (class 3) when `ent_xn` is set. `rsp_instr` is 1 exactly for faults of class 2, 3 or 4 on a fetch. Data aborts of those classes report `ent_domain` on `rsp_domain`; otherwise `rsp_domain` is 0. `rsp_write` is 1 for any fault on a write access.
- R10: `rsp_subcode` equals `ent_section` for faults of class 2, 3 or 4 and is 0 otherwise.
- R11: An access is privileged only when both `cpu_user` and `req_user` are low.
- R12: `rsp_fault` is 1 exactly when the class is nonzero. `rsp_addr` carries `vaddr` on a fault and 0 otherwise. `rsp_cacheable` is 0 whenever `mmu_on` is high or an alignment fault occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| cpu_user | input | 1 | Processor is in user mode |
| req_user | input | 1 | Request flagged as user-mode access |
| vaddr | input | VA_W | Virtual address |
| size_mask | input | MASK_W | Alignment mask of the access size |
| allow_unaligned | input | 1 | Request permits unaligned access |
| mmu_on | input | 1 | Translation enabled |
| align_force | input | 1 | Alignment checking forced on |
| af_enable | input | 1 | Access-flag enable (forces permission bit 0) |
| remap_on | input | 1 | Attribute remap enabled |
| attr_in0 | input | 2 | Region-0 inner cache attribute |
| attr_out0 | input | 2 | Region-0 outer cache attribute |
| type0 | input | 2 | Region-0 memory type |
| dacr | input | 2*2**DOM_W | Domain access word, 2 bits per domain |
| ent_domain | input | DOM_W | Domain of the hit entry |
| ent_perm | input | 3 | Permission code of the hit entry |
| ent_xn | input | 1 | Execute-never bit of the hit entry |
| ent_section | input | 1 | Section/page flag of the hit entry |
| rsp_valid | output | 1 | Verdict valid |
| rsp_fault | output | 1 | Access faulted |
| rsp_class | output | 3 | 0 none, 1 alignment, 2 domain, 3 permission, 4 unpredictable |
| rsp_instr | output | 1 | Instruction abort |
| rsp_write | output | 1 | Faulting access was a write |
| rsp_domain | output | DOM_W | Domain reported with a data abort |
| rsp_subcode | output | 1 | Fault subtype from the section/page flag |
| rsp_addr | output | VA_W | Faulting address |
| rsp_cacheable | output | 1 | Cacheable verdict on the untranslated path |

## Verification
The bench targets the checking order and the decode tables. It sweeps every access kind, privilege pair, domain value, permission code, access-flag setting, execute-never and section flag. A design that tested execute-never before the domain grant would fault fetches under domain value 3. A design that skipped the access-flag override would report code 4 as unpredictable when it should decode as code 5. Alignment sweeps cross every mask and low-address pattern with fetches. Fetches catch a checker that also tests instruction alignment. The sweeps also catch a wrong priority, where a misaligned access is reported as a domain fault. The untranslated-path sweep crosses every attribute value with domain value 0. A design that still consulted the domain word with translation off would fault there. A wrong cacheability term would show up as a miscounted cacheable flag.

// File: rtl/acc_perm_check.sv
module acc_perm_check #(
  parameter int VA_W   = 32,
  parameter int DOM_W  = 4,
  parameter int MASK_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [1:0]                acc_kind,
  input  logic                      cpu_user,
  input  logic                      req_user,
  input  logic [VA_W-1:0]           vaddr,
  input  logic [MASK_W-1:0]         size_mask,
  input  logic                      allow_unaligned,
  input  logic                      mmu_on,
  input  logic                      align_force,
  input  logic                      af_enable,
  input  logic                      remap_on,
  input  logic [1:0]                attr_in0,
  input  logic [1:0]                attr_out0,
  input  logic [1:0]                type0,
  input  logic [2*(2**DOM_W)-1:0]   dacr,
  input  logic [DOM_W-1:0]          ent_domain,
  input  logic [2:0]                ent_perm,
  input  logic                      ent_xn,
  input  logic                      ent_section,
  output logic                      rsp_valid,
  output logic                      rsp_fault,
  output logic [2:0]                rsp_class,
  output logic                      rsp_instr,
  output logic                      rsp_write,
  output logic [DOM_W-1:0]          rsp_domain,
  output logic                      rsp_subcode,
  output logic [VA_W-1:0]           rsp_addr,
  output logic                      rsp_cacheable
);
  localparam logic [2:0] C_NONE  = 3'd0;
  localparam logic [2:0] C_ALIGN = 3'd1;
  localparam logic [2:0] C_DOM   = 3'd2;
  localparam logic [2:0] C_PERM  = 3'd3;
  localparam logic [2:0] C_UNP   = 3'd4;

  wire is_fetch = (acc_kind == 2'b10);
  wire is_write = (acc_kind == 2'b01);
  wire priv     = !cpu_user && !req_user;

  wire align_flt = !is_fetch && (align_force || !allow_unaligned) &&
                   |(vaddr[MASK_W-1:0] & size_mask);

  wire [1:0] dom_val  = dacr[{ent_domain, 1'b0} +: 2];
  wire [2:0] eff_perm = {ent_perm[2:1], ent_perm[0] | af_enable};

  logic perm_abt, perm_unp;
  always_comb begin
    perm_abt = 1'b0;
    perm_unp = 1'b0;
    case (eff_perm)
      3'd0:    perm_abt = 1'b1;
      3'd1:    perm_abt = !priv;
      3'd2:    perm_abt = !priv && is_write;
      3'd3:    perm_abt = 1'b0;
      3'd4:    perm_unp = 1'b1;
      3'd5:    perm_abt = !priv || is_write;
      default: perm_abt = is_write;
    endcase
  end

  logic [2:0] cls;
  logic       cach;
  always_comb begin
    cls  = C_NONE;
    cach = 1'b0;
    if (align_flt)
      cls = C_ALIGN;
    else if (!mmu_on)
      cach = remap_on && |attr_in0 && |attr_out0 && (type0 == 2'd2);
    else begin
      case (dom_val)
        2'd0: cls = C_DOM;
        2'd2: cls = C_UNP;
        2'd1: begin
          if (perm_unp)
            cls = C_UNP;
          else if (perm_abt || (is_fetch && ent_xn))
            cls = C_PERM;
        end
        default: cls = C_NONE;
      endcase
    end
  end

  wire any_flt = (cls != C_NONE);
  wire mmu_flt = (cls == C_DOM) || (cls == C_PERM) || (cls == C_UNP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_fault     <= 1'b0;
      rsp_class     <= C_NONE;
      rsp_instr     <= 1'b0;
      rsp_write     <= 1'b0;
      rsp_domain    <= '0;
      rsp_subcode   <= 1'b0;
      rsp_addr      <= '0;
      rsp_cacheable <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault     <= any_flt;
        rsp_class     <= cls;
        rsp_instr     <= mmu_flt && is_fetch;
        rsp_write     <= any_flt && is_write;
        rsp_domain    <= (mmu_flt && !is_fetch) ? ent_domain : '0;
        rsp_subcode   <= mmu_flt && ent_section;
        rsp_addr      <= any_flt ? vaddr : '0;
        rsp_cacheable <= cach;
      end
    end
  end
endmodule

// File: rtl/acc_perm_check_sva.sv
module acc_perm_check_sva #(
  parameter int DOM_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [1:0]               acc_kind,
  input logic                     mmu_on,
  input logic [2*(2**DOM_W)-1:0]  dacr,
  input logic [DOM_W-1:0]         ent_domain,
  input logic                     rsp_valid,
  input logic                     rsp_fault,
  input logic [2:0]               rsp_class,
  input logic                     rsp_instr
);
  p_resp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_resp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_fetch_no_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_kind == 2'b10) |=> (rsp_class != 3'd1));

  p_mmu_off_fetch_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mmu_on && acc_kind == 2'b10) |=> !rsp_fault);

  p_domain_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mmu_on && acc_kind == 2'b10 &&
     dacr[{ent_domain, 1'b0} +: 2] == 2'd0) |=> (rsp_class == 3'd2));

  p_instr_only_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_kind != 2'b10) |=> !rsp_instr);

  p_fault_has_class_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_class != 3'd0)));
endmodule

bind acc_perm_check acc_perm_check_sva #(.DOM_W(DOM_W)) u_sva (.*);

// File: tb/tb_acc_perm_check.sv
`timescale 1ns/1ps
module tb_acc_perm_check;
  localparam int VA_W = 32, DOM_W = 4, MASK_W = 3;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [1:0] acc_kind = 0;
  logic cpu_user = 0, req_user = 0;
  logic [VA_W-1:0] vaddr = 0;
  logic [MASK_W-1:0] size_mask = 0;
  logic allow_unaligned = 1, mmu_on = 0, align_force = 0, af_enable = 0, remap_on = 0;
  logic [1:0] attr_in0 = 0, attr_out0 = 0, type0 = 0;
  logic [31:0] dacr = 0;
  logic [DOM_W-1:0] ent_domain = 0;
  logic [2:0] ent_perm = 0;
  logic ent_xn = 0, ent_section = 0;
  logic rsp_valid, rsp_fault, rsp_instr, rsp_write, rsp_subcode, rsp_cacheable;
  logic [2:0] rsp_class;
  logic [DOM_W-1:0] rsp_domain;
  logic [VA_W-1:0] rsp_addr;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  acc_perm_check #(.VA_W(VA_W), .DOM_W(DOM_W), .MASK_W(MASK_W)) dut (.*);

  logic e_f, e_i, e_w, e_s, e_c;
  logic [2:0] e_cls;
  logic [DOM_W-1:0] e_d;
  logic [VA_W-1:0] e_a;

  task automatic calc();
    bit fetch, wr, priv, abt, unp;
    logic [1:0] dv;
    logic [2:0] ap;
    fetch = (acc_kind == 2); wr = (acc_kind == 1); priv = !cpu_user && !req_user;
    e_cls = 0; e_c = 0; e_i = 0; e_w = 0; e_d = 0; e_s = 0;
    if (!fetch && (align_force || !allow_unaligned) && ((vaddr[2:0] & size_mask) != 0))
      e_cls = 1;
    else if (!mmu_on)
      e_c = remap_on && attr_in0 != 0 && attr_out0 != 0 && type0 == 2;
    else begin
      dv = 2'((dacr >> (2 * ent_domain)) & 3);
      if (dv == 0) e_cls = 2;
      else if (dv == 2) e_cls = 4;
      else if (dv == 1) begin
        ap = ent_perm | {2'b0, af_enable};
        abt = 0; unp = (ap == 4);
        if (ap == 0) abt = 1;
        if (ap == 1) abt = !priv;
        if (ap == 2) abt = !priv && wr;
        if (ap == 5) abt = !priv || wr;
        if (ap >= 6) abt = wr;
        if (unp) e_cls = 4;
        else if (abt || (fetch && ent_xn)) e_cls = 3;
      end
      if (e_cls >= 2) begin
        e_i = fetch; e_s = ent_section; e_d = fetch ? 0 : ent_domain;
      end
    end
    e_f = (e_cls != 0);
    e_w = e_f && wr;
    e_a = e_f ? vaddr : 0;
  endtask

  task automatic run_one(string tag);
    calc();
    req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    checks++;
    if ({rsp_valid, rsp_fault, rsp_class, rsp_instr, rsp_write, rsp_domain, rsp_subcode, rsp_addr, rsp_cacheable} !==
        {1'b1, e_f, e_cls, e_i, e_w, e_d, e_s, e_a, e_c}) begin
      errors++;
      $display("FAIL %s kind=%0d dacr=%h dom=%0d perm=%0d af=%0d xn=%0d: got v%0d f%0d c%0d i%0d w%0d d%0d s%0d a%h ca%0d exp v1 f%0d c%0d i%0d w%0d d%0d s%0d a%h ca%0d",
        tag, acc_kind, dacr, ent_domain, ent_perm, af_enable, ent_xn,
        rsp_valid, rsp_fault, rsp_class, rsp_instr, rsp_write, rsp_domain, rsp_subcode, rsp_addr, rsp_cacheable,
        e_f, e_cls, e_i, e_w, e_d, e_s, e_a, e_c);
    end
  endtask

  task automatic idle_check();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle: rsp_valid=%0d expected 0", rsp_valid);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_fault !== 0 || rsp_class !== 0) begin
      errors++;
      $display("FAIL R1 reset: v=%0d f=%0d c=%0d expected 0 0 0", rsp_valid, rsp_fault, rsp_class);
    end
    rst_n = 1;
    @(negedge clk);

    // R4 R5 R6 R7 R8 R9 R10 R11 R12: full decode sweep with translation on
    mmu_on = 1; vaddr = 32'h1234_5670; size_mask = 3'b011;
    for (int k = 0; k < 3; k++)
      for (int u = 0; u < 4; u++)
        for (int dv = 0; dv < 4; dv++)
          for (int p = 0; p < 8; p++)
            for (int a = 0; a < 2; a++)
              for (int x = 0; x < 2; x++)
                for (int s = 0; s < 2; s++) begin
                  acc_kind = 2'(k); cpu_user = u[0]; req_user = u[1];
                  ent_domain = 4'((p * 3 + dv + u) % 16);
                  dacr = 32'hAAAA_AAAA;
                  dacr[2*ent_domain +: 2] = 2'(dv);
                  ent_perm = 3'(p); af_enable = a[0]; ent_xn = x[0]; ent_section = s[0];
                  vaddr = 32'h8000_0000 | (32'(k * 1024 + p * 16 + u) << 3);
                  run_one(dv == 0 ? "R4 R10 R12" : dv == 3 ? "R5 R12" : dv == 2 ? "R6 R10" :
                          (a == 1 ? "R8 R7 R11 R9 R10" : "R7 R11 R9 R10 R12"));
                end
    idle_check();

    // R2: alignment sweep, domain grants access so only alignment can fault
    dacr = 32'hFFFF_FFFF; ent_domain = 4'd5;
    for (int k = 0; k < 3; k++)
      for (int f = 0; f < 2; f++)
        for (int al = 0; al < 2; al++)
          for (int m = 0; m < 4; m++)
            for (int lo = 0; lo < 8; lo++) begin
              acc_kind = 2'(k); align_force = f[0]; allow_unaligned = al[0];
              size_mask = 3'((1 << m) - 1);
              vaddr = 32'h0000_4000 | 32'(lo);
              run_one("R2 R12");
            end
    // R2 priority over domain fault
    dacr = 0; acc_kind = 1; align_force = 1; size_mask = 3'b001; vaddr = 32'h21;
    run_one("R2 priority");
    idle_check();

    // R3: untranslated path with a domain word that would fault
    mmu_on = 0; dacr = 0; align_force = 0; allow_unaligned = 1; size_mask = 0;
    for (int k = 0; k < 3; k++)
      for (int r = 0; r < 2; r++)
        for (int i = 0; i < 4; i++)
          for (int o = 0; o < 4; o++)
            for (int t = 0; t < 4; t++) begin
              acc_kind = 2'(k); remap_on = r[0];
              attr_in0 = 2'(i); attr_out0 = 2'(o); type0 = 2'(t);
              vaddr = 32'(k * 100 + t);
              run_one("R3");
            end
    // R12: cacheable stays 0 with translation on even for ideal attributes
    mmu_on = 1; dacr = 32'hFFFF_FFFF; remap_on = 1; attr_in0 = 1; attr_out0 = 1; type0 = 2;
    run_one("R12 cacheable");
    idle_check();

    // R1: back-to-back requests then idle
    for (int n = 0; n < 4; n++) begin
      ent_perm = 3'(n); dacr = 32'h5555_5555; acc_kind = 2'(n % 3);
      run_one("R1 burst");
    end
    idle_check();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule